// File: doc/BRIEF.md
# SDRAM Command Decoder and Protocol Monitor

This block sits passively on the command pins of a single-data-rate SDRAM bus. On every rising clock edge it turns the chip-select, row-strobe, column-strobe, write-enable and clock-enable levels into one decoded command. The command appears on a registered output one cycle later. The block keeps its own picture of which of the four banks hold an open row. From that picture it flags ordering mistakes with a one-cycle error pulse and a code that names the rule that was broken.

When a legal mode-register load passes by, the monitor captures four fields from the address bus: burst length, burst type, CAS latency and the write-burst mode. It holds them on its outputs until the next legal load. A verification environment or a debug probe can use it to see what the controller has programmed and whether the command stream is well formed.

The data bus is not examined. The only timing rule checked is the row-to-column delay, which is set by the parameter `TRCD` in clock cycles.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: When clock enable is high and chip select is low, the pins decode as follows, with (ras_n, cas_n, we_n) given in that order. 111 is NOP = 1, 011 is ACTIVATE = 2, 101 is READ = 3, 100 is WRITE = 4, 010 is PRECHARGE = 5, 001 is REFRESH = 6, 000 is MODE SET = 7, and 110 is BURST STOP = 8.
- R2: The decoded command and the error result of the edge at which the pins were sampled appear on `cmd_o`, `err_o` and `err_code` after exactly one clock edge. When there is no violation, `err_o` is 0 and `err_code` is 0.
- R3: A legal mode set captures four fields from the address bus: burst length from addr[2:0], burst type from addr[3], CAS latency from addr[6:4] and single-write mode from addr[9]. The fields appear on the mode outputs one cycle later, and `mode_valid` goes to 1 at the same time.
- R4: A mode set while any bank is open raises `err_o` with code 1. The captured fields and `mode_valid` stay unchanged.
- R5: An activate before the first legal mode set since reset raises code 2. The bank is still marked open.
- R6: A read or write to a bank with no open row raises code 3.
- R7: A read or write to an open bank fewer than `TRCD` cycles after that bank's activate raises code 4. At exactly `TRCD` cycles or later it is legal.
- R8: A precharge with addr[10] high closes every bank. With addr[10] low it closes only the bank named by `bus_ba`.
- R9: A cycle with chip select high or clock enable low decodes as 0 (deselect). It raises no error and changes no bank or mode state.
- R10: After reset, `cmd_o` is 0, there is no error, every captured field is 0, `mode_valid` is 0 and all banks are closed.
- R11: A later legal mode set overwrites every previously captured field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cke | input | 1 | Clock enable pin |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_ras_n | input | 1 | Row strobe, active low |
| bus_cas_n | input | 1 | Column strobe, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_ba | input | BA_W | Bank address |
| bus_addr | input | ADDR_W | Address bus |
| cmd_o | output | 4 | Decoded command code (R1, R9) |
| err_o | output | 1 | Protocol violation seen on previous edge |
| err_code | output | 3 | Violation code: 1 to 4, or 0 when there is none |
| mode_burst_len | output | 3 | Captured burst length field |
| mode_burst_type | output | 1 | Captured burst type (1 = interleaved) |
| mode_cas_lat | output | 3 | Captured CAS latency field |
| mode_single_write | output | 1 | Captured write-burst mode (1 = single write) |
| mode_valid | output | 1 | A legal mode set has been seen since reset |

## Verification
The hardest case to reach from the ports is a column command that is legal on one bank and early on another in the same window. Each bank keeps its own delay count, and a stale count or a mixed-up index only shows when activates to different banks overlap. A directed sequence first opens bank 1 and hits it before and exactly at the delay boundary. It then closes one bank by address while another stays open. A long seeded random stream follows in which most cycles carry real commands, so that activates, precharges and column accesses to all four banks interleave. A behavioural model compares every cycle, counting elapsed cycles rather than decrementing counters.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_REF   = 4'd6,
    CMD_MRS   = 4'd7,
    CMD_BST   = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_MRS_OPEN   = 3'd1,
    ERR_ACT_EARLY  = 3'd2,
    ERR_COL_CLOSED = 3'd3,
    ERR_COL_TRCD   = 3'd4
  } err_e;

  typedef struct packed {
    logic [2:0] blen;
    logic       btype;
    logic [2:0] clat;
    logic       single_wr;
  } mode_t;

  // Pin levels to command; deselect or clock-enable low means ignore.
  function automatic cmd_e decode_pins(input logic cke, input logic cs_n,
                                       input logic ras_n, input logic cas_n,
                                       input logic we_n);
    cmd_e c;
    if (!cke || cs_n) c = CMD_DESEL;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        default: c = CMD_BST;
      endcase
    end
    return c;
  endfunction

  // Field extraction from the low address bits during a mode set.
  function automatic mode_t mode_from_addr(input logic [9:0] a);
    mode_t m;
    m.blen      = a[2:0];
    m.btype     = a[3];
    m.clat      = a[6:4];
    m.single_wr = a[9];
    return m;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb cmd = decode_pins(cke, cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int BA_W = 2,
  parameter int TRCD = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   act_en,
  input  logic                   pre_en,
  input  logic                   pre_all,
  input  logic [BA_W-1:0]        bank_sel,
  output logic [(1<<BA_W)-1:0]   open_vec,
  output logic [(1<<BA_W)-1:0]   ready_vec
);
  localparam int NUM_BANKS = 1 << BA_W;
  localparam int CW        = (TRCD < 2) ? 1 : $clog2(TRCD + 1);
  localparam logic [CW-1:0] LOAD = CW'(TRCD - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic          is_sel;
    logic          open_q;
    logic [CW-1:0] wait_q;

    assign is_sel = (bank_sel == BA_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        wait_q <= '0;
      end else begin
        if (act_en && is_sel) begin
          open_q <= 1'b1;
          wait_q <= LOAD;
        end else begin
          if (pre_en && (pre_all || is_sel)) open_q <= 1'b0;
          if (wait_q != '0) wait_q <= wait_q - 1'b1;
        end
      end
    end

    assign open_vec[b]  = open_q;
    assign ready_vec[b] = (wait_q == '0);
  end
endmodule

// File: rtl/sdram_mode_capture.sv
module sdram_mode_capture
  import sdram_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [9:0] addr_lo,
  output mode_t      mode,
  output logic       valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      mode  <= mode_from_addr(addr_lo);
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int TRCD   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cke,
  input  logic              bus_cs_n,
  input  logic              bus_ras_n,
  input  logic              bus_cas_n,
  input  logic              bus_we_n,
  input  logic [BA_W-1:0]   bus_ba,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        cmd_o,
  output logic              err_o,
  output logic [2:0]        err_code,
  output logic [2:0]        mode_burst_len,
  output logic              mode_burst_type,
  output logic [2:0]        mode_cas_lat,
  output logic              mode_single_write,
  output logic              mode_valid
);
  localparam int NUM_BANKS = 1 << BA_W;

  cmd_e                 cmd_now;
  logic [NUM_BANKS-1:0] open_vec;
  logic [NUM_BANKS-1:0] ready_vec;
  mode_t                mode_q;

  // Named events for the checker.
  logic act_fire, col_fire, pre_fire, mrs_fire;
  logic any_open, sel_open, sel_ready;
  logic viol_mrs, viol_act, viol_closed, viol_trcd, mrs_ok;
  err_e err_next;

  sdram_cmd_decode u_dec (
    .cke(bus_cke), .cs_n(bus_cs_n), .ras_n(bus_ras_n),
    .cas_n(bus_cas_n), .we_n(bus_we_n), .cmd(cmd_now)
  );

  assign act_fire  = (cmd_now == CMD_ACT);
  assign col_fire  = (cmd_now == CMD_RD) || (cmd_now == CMD_WR);
  assign pre_fire  = (cmd_now == CMD_PRE);
  assign mrs_fire  = (cmd_now == CMD_MRS);
  assign any_open  = |open_vec;
  assign sel_open  = open_vec[bus_ba];
  assign sel_ready = ready_vec[bus_ba];

  assign viol_mrs    = mrs_fire && any_open;
  assign mrs_ok      = mrs_fire && !any_open;
  assign viol_act    = act_fire && !mode_valid;
  assign viol_closed = col_fire && !sel_open;
  assign viol_trcd   = col_fire && sel_open && !sel_ready;

  sdram_bank_tracker #(.BA_W(BA_W), .TRCD(TRCD)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(act_fire), .pre_en(pre_fire), .pre_all(bus_addr[10]),
    .bank_sel(bus_ba), .open_vec(open_vec), .ready_vec(ready_vec)
  );

  sdram_mode_capture u_mode (
    .clk(clk), .rst_n(rst_n), .load(mrs_ok),
    .addr_lo(bus_addr[9:0]), .mode(mode_q), .valid(mode_valid)
  );

  always_comb begin
    err_next = ERR_NONE;
    if      (viol_mrs)    err_next = ERR_MRS_OPEN;
    else if (viol_act)    err_next = ERR_ACT_EARLY;
    else if (viol_closed) err_next = ERR_COL_CLOSED;
    else if (viol_trcd)   err_next = ERR_COL_TRCD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o    <= 4'(CMD_DESEL);
      err_o    <= 1'b0;
      err_code <= 3'(ERR_NONE);
    end else begin
      cmd_o    <= 4'(cmd_now);
      err_o    <= (err_next != ERR_NONE);
      err_code <= 3'(err_next);
    end
  end

  assign mode_burst_len    = mode_q.blen;
  assign mode_burst_type   = mode_q.btype;
  assign mode_cas_lat      = mode_q.clat;
  assign mode_single_write = mode_q.single_wr;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cke,
  input logic          bus_cs_n,
  input logic          pre_all_bit,
  input cmd_e          cmd_now,
  input logic          any_open,
  input logic          sel_open,
  input logic          sel_ready,
  input logic          mode_valid,
  input logic [NB-1:0] open_vec,
  input logic [3:0]    cmd_o,
  input logic          err_o,
  input logic [2:0]    err_code,
  input logic [7:0]    mode_bits
);
  p_mrs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == CMD_MRS && any_open) |=> (err_o && err_code == 3'd1));

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_now == CMD_MRS && !any_open) |=> $stable(mode_bits));

  p_act_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == CMD_ACT && !mode_valid) |=> (err_o && err_code == 3'd2));

  p_col_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_now == CMD_RD || cmd_now == CMD_WR) && !sel_open)
      |=> (err_code == 3'd3));

  p_col_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_now == CMD_RD || cmd_now == CMD_WR) && sel_open && !sel_ready)
      |=> (err_code == 3'd4));

  p_pre_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == CMD_PRE && pre_all_bit) |=> (open_vec == '0));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_n || !bus_cke) |=> (cmd_o == 4'd0 && !err_o && $stable(open_vec)));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NB(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cke(bus_cke), .bus_cs_n(bus_cs_n),
  .pre_all_bit(bus_addr[10]), .cmd_now(cmd_now), .any_open(any_open),
  .sel_open(sel_open), .sel_ready(sel_ready), .mode_valid(mode_valid),
  .open_vec(open_vec), .cmd_o(cmd_o), .err_o(err_o), .err_code(err_code),
  .mode_bits({mode_burst_len, mode_burst_type, mode_cas_lat, mode_single_write})
);

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TRCD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0] cmd_o;
  logic err_o, btype, swr, mvalid;
  logic [2:0] err_code, blen, clat;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor #(.ADDR_W(13), .BA_W(2), .TRCD(TRCD)) u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .bus_cke(cke), .bus_cs_n(cs_n),
    .bus_ras_n(ras_n), .bus_cas_n(cas_n), .bus_we_n(we_n),
    .bus_ba(ba), .bus_addr(addr), .cmd_o(cmd_o), .err_o(err_o),
    .err_code(err_code), .mode_burst_len(blen), .mode_burst_type(btype),
    .mode_cas_lat(clat), .mode_single_write(swr), .mode_valid(mvalid)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  // Reference state
  bit m_open[4];
  int m_act_at[4];
  bit m_seen = 0;
  int m_blen = 0, m_bt = 0, m_cl = 0, m_sw = 0;

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle with pins in (ras,cas,we) order, model it, compare after the edge.
  task automatic step(string tag, bit k, bit c, bit r, bit ca, bit w,
                      int b, int a);
    int ecmd, eerr;
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w;
    ba = 2'(b); addr = 13'(a);
    cyc++;
    ecmd = 0; eerr = 0;
    if (k && !c) begin
      case ({r, ca, w})
        3'b111: ecmd = 1;
        3'b011: ecmd = 2;
        3'b101: ecmd = 3;
        3'b100: ecmd = 4;
        3'b010: ecmd = 5;
        3'b001: ecmd = 6;
        3'b000: ecmd = 7;
        default: ecmd = 8;
      endcase
    end
    case (ecmd)
      2: begin
        if (!m_seen) eerr = 2;
        m_open[b] = 1; m_act_at[b] = cyc;
      end
      3, 4: begin
        if (!m_open[b]) eerr = 3;
        else if (cyc - m_act_at[b] < TRCD) eerr = 4;
      end
      5: begin
        if (a[10]) foreach (m_open[i]) m_open[i] = 0;
        else m_open[b] = 0;
      end
      7: begin
        if (m_open[0] || m_open[1] || m_open[2] || m_open[3]) eerr = 1;
        else begin
          m_seen = 1;
          m_blen = a & 7; m_bt = (a >> 3) & 1;
          m_cl = (a >> 4) & 7; m_sw = (a >> 9) & 1;
        end
      end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    check(tag, "cmd", cmd_o, ecmd);
    check(tag, "err_code", err_code, eerr);
    check(tag, "err_o", err_o, eerr != 0);
    check(tag, "mode", {blen, btype, clat, swr, mvalid},
          {3'(m_blen), 1'(m_bt), 3'(m_cl), 1'(m_sw), 1'(m_seen)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    foreach (m_open[i]) begin m_open[i] = 0; m_act_at[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check("R10", "cmd", cmd_o, 0);
    check("R10", "err", {err_o, err_code}, 0);
    check("R10", "mode", {blen, btype, clat, swr, mvalid}, 0);
    // R9: deselect with row strobe low, and clock enable low with mode-set pins
    step("R9", 1, 1, 0, 1, 1, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 13'h3ff);
    step("R1", 1, 0, 1, 1, 1, 0, 0);           // NOP
    // R5: activate before mode set
    step("R5", 1, 0, 0, 1, 1, 0, 5);
    // R4: mode set with bank 0 open; fields must stay
    step("R4", 1, 0, 0, 0, 0, 0, 13'h27b);
    // R8: precharge all
    step("R8", 1, 0, 0, 1, 0, 2, 13'h400);
    step("R6", 1, 0, 1, 0, 1, 0, 0);           // read bank 0 now closed
    // R3: legal mode set: bl=3 bt=1 cl=2 single write
    step("R3", 1, 0, 0, 0, 0, 0, (1 << 9) | (2 << 4) | (1 << 3) | 3);
    step("R6", 1, 0, 1, 0, 0, 1, 0);           // write to closed bank 1
    // R7: delay boundary on bank 1
    step("R7", 1, 0, 0, 1, 1, 1, 7);           // activate bank 1
    step("R7", 1, 0, 1, 0, 1, 1, 0);           // one cycle: early
    step("R7", 1, 0, 1, 1, 1, 1, 0);           // NOP
    step("R7", 1, 0, 1, 0, 0, 1, 0);           // exactly TRCD: legal write
    // R8: single-bank precharge keeps bank 1 open
    step("R8", 1, 0, 0, 1, 1, 2, 0);           // activate bank 2
    step("R8", 1, 0, 0, 1, 0, 2, 0);           // precharge bank 2 only
    step("R8", 1, 0, 1, 0, 1, 2, 0);           // read bank 2: closed
    step("R8", 1, 0, 1, 0, 1, 1, 0);           // read bank 1: legal
    step("R1", 1, 0, 0, 0, 1, 0, 0);           // refresh
    step("R1", 1, 0, 1, 1, 0, 0, 0);           // burst stop
    step("R4", 1, 0, 0, 0, 0, 0, 13'h000);     // bank 1 open: rejected
    step("R8", 1, 0, 0, 1, 0, 0, 13'h400);
    // R11: new mode set overwrites every field
    step("R11", 1, 0, 0, 0, 0, 0, (3 << 4) | 2);
    // R2: seeded random stream compared every cycle
    for (int i = 0; i < 600; i++) begin
      int p, bb, aa;
      p = $urandom_range(0, 15);
      bb = $urandom_range(0, 3);
      aa = $urandom_range(0, 8191);
      step("R2", p != 0, p == 1, p[0], p[1], p[2] ^ p[3], bb, aa);
    end
    finish_run();
  end
endmodule